// File: doc/BRIEF.md
# Baud Divisor Search Engine

This block picks the two divide factors of a two-stage serial baud generator. A prescale stage divides the master clock by a 16-bit count (bgen), and a second stage divides that result by the 8-bit value bdiv plus one. On a start pulse the engine captures the master clock frequency and the wanted baud rate, both in hertz. It then tries bdiv candidates one after another, finds the prescale count that each candidate implies, and returns the first pair whose achieved rate is close enough to the target.

All divisions run on one shared restoring divider that produces one quotient bit per clock. A candidate that needs a prescale count out of range costs one division. A candidate that is in range costs two: one for the count and one for the rate that count achieves. When a result is ready the engine raises a one-cycle completion pulse. The result stays on its outputs until the next search finishes.

Top module: `baud_pair_finder`

## Requirements
- R1: bdiv candidates are tried in ascending order from 4 up to 254, and the first candidate that passes is returned on bdiv_o.
- R2: For a candidate d, the prescale count is floor(clock / (target × (d + 1))), and for a passing candidate this is the value on bgen_o.
- R3: A candidate whose prescale count is less than 2 or greater than 65535 is rejected without an error test, and the search moves on to the next candidate.
- R4: For an in-range count g, the achieved rate is floor(clock / (g × (d + 1))). The candidate passes when floor(|achieved − target| × 100 / target) < 3.
- R5: When the captured clock is below 1,000,000 and the requested baud is above 4800, the target used by the search is 4800.
- R6: When no candidate passes, bdiv_o reads 255 and bgen_o holds the low 16 bits of the prescale count computed for candidate 254.
- R7: A start with baud_i equal to zero gives done_o high in the cycle after start is sampled, with bgen_o and bdiv_o both zero.
- R8: done_o is high for exactly one cycle per search, and bgen_o and bdiv_o change only in a cycle in which done_o is high.
- R9: The clock and baud inputs are captured when start is accepted. A start pulse or an input change while a search is running has no effect on that search's result.
- R10: After reset done_o, bgen_o and bdiv_o are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Starts a search when the engine is idle |
| mclk_hz_i | input | 32 | Master clock frequency in Hz |
| baud_i | input | 32 | Requested baud rate in Hz |
| done_o | output | 1 | One-cycle pulse when a result is ready |
| bgen_o | output | 16 | Selected prescale count |
| bdiv_o | output | 8 | Selected second-stage divide value |

## Verification
The bench aims at the places where a first-fit search goes wrong quietly. The first is a prescale count just above 65535 at bdiv 4: a design that clipped the count instead of skipping the candidate would return bdiv 4. The second is the slow-clock clamp: without it the engine would search for a rate the clock cannot produce and end on 255. The third is the exhausted search, in both directions: counts always below 2, and counts always above 65535, where a design that kept an older count or stopped at 254 shows a wrong pair. A zero baud rate must complete at once instead of hanging in a divide by zero. A second start during a run must not restart the search or cut it short.

// File: rtl/bpf_pkg.sv
// Package for the baud divisor search engine.
// Holds the controller state encoding used by the top module.
package bpf_pkg;

    // Search controller states
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GEN_GO,
        ST_GEN_WAIT,
        ST_RATE_GO,
        ST_RATE_WAIT,
        ST_NEXT
    } bpf_state_e;

endpackage

// File: rtl/bpf_serial_div.sv
// Restoring serial divider: one quotient bit per clock.
// A go pulse captures the numerator and denominator. After NUM_W active
// cycles fin_o pulses for one cycle, and quo_o then holds until the next go.
// Assumes the denominator is non-zero and that go does not arrive mid-run.
module bpf_serial_div #(
    parameter int NUM_W = 32,
    parameter int DEN_W = 41
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_i,
    input  logic [NUM_W-1:0] num_i,
    input  logic [DEN_W-1:0] den_i,
    output logic             fin_o,
    output logic [NUM_W-1:0] quo_o
);
    localparam int CNT_W = $clog2(NUM_W + 1);
    localparam int PW    = NUM_W + DEN_W;

    logic [DEN_W-1:0] rem_q;
    logic [NUM_W-1:0] sh_q;
    logic [NUM_W-1:0] num_r;
    logic [DEN_W-1:0] den_r;
    logic [CNT_W-1:0] left_q;
    logic             run_q;
    logic [DEN_W:0]   trial;
    logic             fits;

    // Trial remainder: the partial remainder with the next numerator bit shifted in
    always_comb begin
        trial = {rem_q, sh_q[NUM_W-1]};
        fits  = trial >= {1'b0, den_r};
    end

    // Iteration register: load on go, then one restoring step per cycle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q  <= '0;
            sh_q   <= '0;
            num_r  <= '0;
            den_r  <= '0;
            quo_o  <= '0;
            left_q <= '0;
            run_q  <= 1'b0;
            fin_o  <= 1'b0;
        end else begin
            fin_o <= 1'b0;
            if (go_i) begin
                rem_q  <= '0;
                sh_q   <= num_i;
                num_r  <= num_i;
                den_r  <= den_i;
                quo_o  <= '0;
                left_q <= CNT_W'(NUM_W);
                run_q  <= 1'b1;
            end else if (run_q) begin
                rem_q  <= fits ? DEN_W'(trial - {1'b0, den_r}) : DEN_W'(trial);
                sh_q   <= {sh_q[NUM_W-2:0], 1'b0};
                quo_o  <= {quo_o[NUM_W-2:0], fits};
                left_q <= left_q - CNT_W'(1);
                if (left_q == CNT_W'(1)) begin
                    run_q <= 1'b0;
                    fin_o <= 1'b1;
                end
            end
        end
    end

    // R2
    quo_exact_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fin_o |-> ((PW'(quo_o) * PW'(den_r) <= PW'(num_r)) &&
                   (PW'(num_r) < PW'(quo_o) * PW'(den_r) + PW'(den_r))));

    // R4
    rem_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> (rem_q < den_r));

endmodule

// File: rtl/bpf_err_judge.sv
// Rate error judge: decides whether an achieved rate is within the allowed
// percentage of the target. Compares err*SCALE against target*LIMIT, which
// equals floor(err*SCALE/target) < LIMIT for integers, so no divide is needed.
// Purely combinational; assumes the target is non-zero.
module bpf_err_judge #(
    parameter int TGT_W     = 32,
    parameter int ACH_W     = 32,
    parameter int PCT_SCALE = 100,
    parameter int ERR_LIMIT = 3
) (
    input  logic [TGT_W-1:0] target_i,
    input  logic [ACH_W-1:0] achieved_i,
    output logic             pass_o
);
    localparam int W  = (TGT_W > ACH_W) ? TGT_W : ACH_W;
    localparam int SW = $clog2(PCT_SCALE + ERR_LIMIT + 1);
    localparam int PW = W + SW;

    logic [W-1:0]  tgt_x;
    logic [W-1:0]  ach_x;
    logic [W-1:0]  err;
    logic [PW-1:0] lhs;
    logic [PW-1:0] rhs;

    // Absolute error and the scaled comparison
    always_comb begin
        tgt_x  = W'(target_i);
        ach_x  = W'(achieved_i);
        err    = (ach_x > tgt_x) ? (ach_x - tgt_x) : (tgt_x - ach_x);
        lhs    = PW'(err) * PW'(PCT_SCALE);
        rhs    = PW'(tgt_x) * PW'(ERR_LIMIT);
        pass_o = lhs < rhs;
    end

endmodule

// File: rtl/baud_pair_finder.sv
// Baud divisor search engine (top).
// On an accepted start it captures clock and baud, clamps the target for slow
// clocks, and walks bdiv from BDIV_FIRST to BDIV_LAST. Each step divides for
// the prescale count and, when that count is in range, divides again for the
// achieved rate. The first passing pair, or the last state with bdiv = LAST+1,
// is registered on the outputs together with a one-cycle done pulse.
// Assumes one shared divider; start is ignored while a search runs.
module baud_pair_finder #(
    parameter int CLK_W      = 32,
    parameter int BAUD_W     = 32,
    parameter int GEN_W      = 16,
    parameter int DIV_W      = 8,
    parameter int BDIV_FIRST = 4,
    parameter int BDIV_LAST  = 254,
    parameter int GEN_MIN    = 2,
    parameter int PCT_SCALE  = 100,
    parameter int ERR_LIMIT  = 3,
    parameter int SLOW_CLK   = 1000000,
    parameter int SLOW_BAUD  = 4800
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [CLK_W-1:0]  mclk_hz_i,
    input  logic [BAUD_W-1:0] baud_i,
    output logic              done_o,
    output logic [GEN_W-1:0]  bgen_o,
    output logic [DIV_W-1:0]  bdiv_o
);
    import bpf_pkg::*;

    localparam int DEN_W = BAUD_W + DIV_W + 1;
    localparam logic [CLK_W-1:0] GEN_MAX_V = CLK_W'((64'd1 << GEN_W) - 64'd1);
    localparam logic [CLK_W-1:0] GEN_MIN_V = CLK_W'(GEN_MIN);
    localparam logic [DIV_W-1:0] CAND_LO   = DIV_W'(BDIV_FIRST);
    localparam logic [DIV_W-1:0] CAND_HI   = DIV_W'(BDIV_LAST);
    localparam logic [DIV_W-1:0] CAND_END  = DIV_W'(BDIV_LAST + 1);

    bpf_state_e         st_q;
    logic [CLK_W-1:0]   clk_r;
    logic [BAUD_W-1:0]  tgt_r;
    logic [DIV_W-1:0]   cand_r;
    logic [GEN_W-1:0]   gen_r;
    logic [DIV_W:0]     cand_p1;
    logic [DEN_W-1:0]   den_gen;
    logic [DEN_W-1:0]   den_rate;
    logic               div_go;
    logic [DEN_W-1:0]   div_den;
    logic               div_fin;
    logic [CLK_W-1:0]   div_quo;
    logic               gen_ok;
    logic               rate_pass;
    logic               slow_req;

    // Divisor operands for the two divisions of the current candidate
    always_comb begin
        cand_p1  = {1'b0, cand_r} + (DIV_W+1)'(1);
        den_gen  = DEN_W'(tgt_r) * DEN_W'(cand_p1);
        den_rate = DEN_W'(gen_r) * DEN_W'(cand_p1);
        div_go   = (st_q == ST_GEN_GO) || (st_q == ST_RATE_GO);
        div_den  = (st_q == ST_RATE_GO) ? den_rate : den_gen;
        gen_ok   = (div_quo >= GEN_MIN_V) && (div_quo <= GEN_MAX_V);
        slow_req = (mclk_hz_i < CLK_W'(SLOW_CLK)) && (baud_i > BAUD_W'(SLOW_BAUD));
    end

    bpf_serial_div #(
        .NUM_W (CLK_W),
        .DEN_W (DEN_W)
    ) u_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go_i  (div_go),
        .num_i (clk_r),
        .den_i (div_den),
        .fin_o (div_fin),
        .quo_o (div_quo)
    );

    bpf_err_judge #(
        .TGT_W     (BAUD_W),
        .ACH_W     (CLK_W),
        .PCT_SCALE (PCT_SCALE),
        .ERR_LIMIT (ERR_LIMIT)
    ) u_judge (
        .target_i   (tgt_r),
        .achieved_i (div_quo),
        .pass_o     (rate_pass)
    );

    // Search controller: candidate stepping, result capture and done pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= ST_IDLE;
            clk_r  <= '0;
            tgt_r  <= '0;
            cand_r <= '0;
            gen_r  <= '0;
            done_o <= 1'b0;
            bgen_o <= '0;
            bdiv_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (st_q)
                ST_IDLE: begin
                    if (start_i) begin
                        if (baud_i == '0) begin
                            bgen_o <= '0;
                            bdiv_o <= '0;
                            done_o <= 1'b1;
                        end else begin
                            clk_r  <= mclk_hz_i;
                            tgt_r  <= slow_req ? BAUD_W'(SLOW_BAUD) : baud_i;
                            cand_r <= CAND_LO;
                            st_q   <= ST_GEN_GO;
                        end
                    end
                end
                ST_GEN_GO: st_q <= ST_GEN_WAIT;
                ST_GEN_WAIT: begin
                    if (div_fin) begin
                        gen_r <= div_quo[GEN_W-1:0];
                        st_q  <= gen_ok ? ST_RATE_GO : ST_NEXT;
                    end
                end
                ST_RATE_GO: st_q <= ST_RATE_WAIT;
                ST_RATE_WAIT: begin
                    if (div_fin) begin
                        if (rate_pass) begin
                            bgen_o <= gen_r;
                            bdiv_o <= cand_r;
                            done_o <= 1'b1;
                            st_q   <= ST_IDLE;
                        end else begin
                            st_q <= ST_NEXT;
                        end
                    end
                end
                ST_NEXT: begin
                    if (cand_r == CAND_HI) begin
                        bgen_o <= gen_r;
                        bdiv_o <= CAND_END;
                        done_o <= 1'b1;
                        st_q   <= ST_IDLE;
                    end else begin
                        cand_r <= cand_r + DIV_W'(1);
                        st_q   <= ST_GEN_GO;
                    end
                end
                default: st_q <= ST_IDLE;
            endcase
        end
    end

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(bgen_o) && $stable(bdiv_o)));

    // R9
    capture_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != ST_IDLE) |=> ($stable(clk_r) && $stable(tgt_r)));

    // R1
    bdiv_span_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ((bdiv_o == '0) || ((bdiv_o >= CAND_LO) && (bdiv_o <= CAND_END))));

    // R3
    gen_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && (bdiv_o >= CAND_LO) && (bdiv_o <= CAND_HI)) |-> (CLK_W'(bgen_o) >= GEN_MIN_V));

    // R5
    slow_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == ST_GEN_GO) && (clk_r < CLK_W'(SLOW_CLK))) |-> (tgt_r <= BAUD_W'(SLOW_BAUD)));

endmodule

// File: tb/test_baud_pair_finder.sv
`timescale 1ns/1ps
module test_baud_pair_finder;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        start_i;
    logic [31:0] mclk_hz_i;
    logic [31:0] baud_i;
    logic        done_o;
    logic [15:0] bgen_o;
    logic [7:0]  bdiv_o;

    int n_cmp = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    baud_pair_finder i_baud_pair_finder (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (start_i),
        .mclk_hz_i (mclk_hz_i),
        .baud_i    (baud_i),
        .done_o    (done_o),
        .bgen_o    (bgen_o),
        .bdiv_o    (bdiv_o)
    );

    // Expected result computed from the requirements
    function automatic void model(input longint unsigned c, input longint unsigned b_in,
                                  output longint unsigned g, output longint unsigned d);
        longint unsigned b, q, a, e;
        bit found;
        b = b_in;
        g = 0; d = 0; q = 0; found = 0;
        if (b == 0) return;
        if (c < 1000000 && b > 4800) b = 4800;
        for (int k = 4; k < 255; k++) begin
            if (!found) begin
                q = c / (b * longint'(k + 1));
                if (q >= 2 && q <= 65535) begin
                    a = c / (q * longint'(k + 1));
                    e = (a > b) ? a - b : b - a;
                    if ((e * 100) / b < 3) begin
                        found = 1;
                        g = q & 64'hffff;
                        d = k;
                    end
                end
            end
        end
        if (!found) begin
            g = q & 64'hffff;
            d = 255;
        end
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wait_done(output bit seen);
        seen = 0;
        for (int i = 0; i < 30000; i++) begin
            @(negedge clk);
            if (done_o) begin
                seen = 1;
                break;
            end
        end
    endtask

    task automatic run_case(input longint unsigned c, input longint unsigned b, input string req);
        longint unsigned eg, ed;
        bit seen;
        logic [15:0] g0;
        logic [7:0]  d0;
        model(c, b, eg, ed);
        @(negedge clk);
        mclk_hz_i = 32'(c);
        baud_i    = 32'(b);
        start_i   = 1'b1;
        @(negedge clk);
        start_i   = 1'b0;
        wait_done(seen);
        chk(seen, req, "done seen", longint'(seen), 1);
        chk(bgen_o == 16'(eg), req, "bgen", bgen_o, eg);
        chk(bdiv_o == 8'(ed), req, "bdiv", bdiv_o, ed);
        g0 = bgen_o; d0 = bdiv_o;
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done width", done_o, 0);
        mclk_hz_i = $urandom; baud_i = $urandom;
        repeat (3) @(negedge clk);
        chk(bgen_o == g0 && bdiv_o == d0, "R8", "hold bgen", bgen_o, g0);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (195000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        longint unsigned eg, ed;
        void'($urandom(32'd24681));
        rst_n = 1'b0; start_i = 1'b0; mclk_hz_i = '0; baud_i = '0;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        chk(done_o == 1'b0, "R10", "done", done_o, 0);
        chk(bgen_o == 16'd0, "R10", "bgen", bgen_o, 0);
        chk(bdiv_o == 8'd0, "R10", "bdiv", bdiv_o, 0);

        // R2 / R4: passes at the first candidate
        run_case(100000000, 115200, "R2/R4");
        // R3: count above 65535 at bdiv 4, legal at bdiv 5
        run_case(100000000, 300, "R3");
        // R5 / R1: clamped target, first candidate fails the error test
        run_case(500000, 115200, "R5/R1");
        // R5: slow clock at the clamp limit is not clamped
        run_case(999999, 4800, "R5");
        // R6: every count below 2
        run_case(1000, 1000, "R6");
        // R6: every count above 65535
        run_case(64'd4000000000, 1, "R6");
        // R1: assorted directed rates
        run_case(33333333, 9600, "R1");
        run_case(50000000, 921600, "R1");

        // R7: zero baud completes on the next cycle
        @(negedge clk);
        mclk_hz_i = 32'd100000000; baud_i = 32'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b1, "R7", "done next cycle", done_o, 1);
        chk(bgen_o == 16'd0 && bdiv_o == 8'd0, "R7", "zero result", {bgen_o, bdiv_o}, 0);
        @(negedge clk);
        chk(done_o == 1'b0, "R8", "done width", done_o, 0);

        // R9: start and input changes during a search are ignored
        model(100000000, 300, eg, ed);
        mclk_hz_i = 32'd100000000; baud_i = 32'd300; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        mclk_hz_i = 32'd7000000; baud_i = 32'd2400;
        repeat (4) @(negedge clk);
        baud_i = 32'd0; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(done_o == 1'b0, "R9", "no early done", done_o, 0);
        wait_done(seen);
        chk(seen, "R9", "done seen", longint'(seen), 1);
        chk(bgen_o == 16'(eg) && bdiv_o == 8'(ed), "R9", "first request result",
            {bgen_o, bdiv_o}, {eg[15:0], ed[7:0]});

        // R1 / R2 / R4: constrained random requests
        for (int n = 0; n < 14; n++) begin
            longint unsigned c, b;
            c = 10000000 + ($urandom % 190000000);
            b = 1200 + ($urandom % 250000);
            run_case(c, b, "R1/R2/R4");
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule